// File: doc/BRIEF.md
# Audio Frame Clock Ratio Detector

This block sits beside a serial audio port that runs as a clock follower. It watches the bit clock and the frame sync and measures two things. The first is how many bit clocks fall in one frame. The second is how fast frames arrive, timed against a free-running reference clock. From these it reports a ratio code, a rate code and a flag for the 44.1 kHz rate family. Downstream clocking can then be set up with no host writes.

Each completed frame is checked against a fixed set of legal ratios and legal rates. The implied bit clock frequency (ratio times rate) must also sit inside a window. The bottom of the window is fixed. The top depends on a static supply-mode pin. An illegal or reserved frame raises an error flag. A steady, legal configuration raises a lock flag once several identical frames in a row have been seen.

Top module: `afd_top`

## Requirements
- R1: The ratio is the count of bit clock rising edges between successive frame sync rising edges. Only 16, 24, 32, 48, 64, 96, 128, 192, 256, 384 and 512 are accepted. `ratio_code` is 0 to 10 in that ascending order, so 16 is 0, 24 is 1 and 512 is 10.
- R2: A frame period counts as a legal rate when it lies within ±2% of the nominal period of one of these rates: 8, 16, 24, 32, 48, 96 or 192 kHz (`fam_44k`=0), or 7.35, 14.7, 22.05, 29.4, 44.1, 88.2 or 176.4 kHz (`fam_44k`=1). `rate_code` is 0 to 6, ascending within the family.
- R3: A combination whose bit clock frequency (ratio × rate) is below 256 kHz is reserved. Exactly 256 kHz is legal.
- R4: With `low_supply`=0 the bit clock ceiling is 24.576 MHz. With `low_supply`=1 it is 12.288 MHz. Above the ceiling is reserved, and the ceiling value itself is legal.
- R5: A ratio outside the set in R1, or a period outside every window in R2, sets `cfg_err`.
- R6: `locked` rises at the evaluation of the fourth consecutive legal frame with identical codes, and not before.
- R7: A legal frame whose codes differ from the reported ones updates the codes and drops `locked` in the same cycle, keeps `cfg_err` low, and restarts qualification at one frame.
- R8: An illegal or reserved frame sets `cfg_err` and clears `locked`. The codes keep their last legal values. `locked` and `cfg_err` are never high together.
- R9: If no frame sync rising edge arrives for the full reach of the period counter (8191 reference cycles by default), `cfg_err` rises and `locked` falls.
- R10: During and right after reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | Serial audio bit clock |
| fsync | input | 1 | Serial audio frame sync |
| low_supply | input | 1 | Static; 1 selects the lower bit clock ceiling |
| ratio_code | output | 4 | Detected bit clocks per frame, encoded as in R1 |
| rate_code | output | 3 | Detected frame rate within its family |
| fam_44k | output | 1 | 1 when the rate belongs to the 44.1 kHz family |
| locked | output | 1 | Configuration stable for the qualification count |
| cfg_err | output | 1 | Last measurement illegal, reserved or stalled |

## Verification
Lock hysteresis and code reporting act in the same evaluation cycle when the stream moves, with no gap, from one legal setting to another. At that moment `locked` falls and all three code fields take the new values. The bench sets this up by moving a locked stream from 64 clocks at 48 kHz to 96 clocks at 44.1 kHz. It then samples every reference cycle to find the cycle in which `locked` falls. In that same sample it requires the new codes and a low error flag. It then checks that `locked` is still low two and a half frames later and high one frame after that.

// File: rtl/afd_pkg.sv
package afd_pkg;

  localparam int NUM_RATIOS      = 11;
  localparam int NUM_RATES       = 7;
  localparam int BCLK_FLOOR_HZ   = 256_000;
  localparam int BCLK_CEIL_HI_HZ = 24_576_000;
  localparam int BCLK_CEIL_LO_HZ = 12_288_000;
  localparam int TOL_DIV         = 50;   // 1/50 = 2 %
  localparam int FAM48_BASE_HZ   = 8000;
  localparam int FAM44_BASE_HZ   = 7350;

  typedef logic [3:0] ratio_code_t;
  typedef logic [2:0] rate_code_t;

  typedef struct packed {
    ratio_code_t ratio;
    rate_code_t  rate;
    logic        fam44;
  } frame_cfg_t;

  // even codes are 16*2^k, odd codes are 24*2^k
  function automatic int ratio_value(int idx);
    int base;
    base = (idx % 2 == 1) ? 24 : 16;
    return base << (idx / 2);
  endfunction

  function automatic int rate_mult(int idx);
    case (idx)
      0: return 1;
      1: return 2;
      2: return 3;
      3: return 4;
      4: return 6;
      5: return 12;
      default: return 24;
    endcase
  endfunction

  function automatic int rate_value(logic fam44, int idx);
    return (fam44 ? FAM44_BASE_HZ : FAM48_BASE_HZ) * rate_mult(idx);
  endfunction

  function automatic int nominal_period(int ref_hz, logic fam44, int idx);
    return ref_hz / rate_value(fam44, idx);
  endfunction

  function automatic logic period_matches(int per, int nom);
    int diff;
    diff = (per > nom) ? per - nom : nom - per;
    return diff <= nom / TOL_DIV;
  endfunction

  function automatic logic bclk_in_window(int ratio, int rate, logic low);
    int prod;
    int ceil_hz;
    prod    = ratio * rate;
    ceil_hz = low ? BCLK_CEIL_LO_HZ : BCLK_CEIL_HI_HZ;
    return (prod >= BCLK_FLOOR_HZ) && (prod <= ceil_hz);
  endfunction

endpackage

// File: rtl/afd_bclk_counter.sv
// Bit clock domain: counts rising edges per frame and hands each result
// to the reference domain through a toggle.
module afd_bclk_counter #(
  parameter int RAT_W = 10
) (
  input  logic             bclk,
  input  logic             rst_n,
  input  logic             fsync_i,
  output logic [RAT_W-1:0] ratio_hold_o,
  output logic             tog_o
);
  localparam logic [RAT_W-1:0] CNT_MAX = '1;

  logic [1:0]       rst_sr;
  logic             rst_b;
  logic [2:0]       fs_sr;
  logic             fs_rise;
  logic             armed;
  logic [RAT_W-1:0] edge_cnt;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) rst_sr <= '0;
    else        rst_sr <= {rst_sr[0], 1'b1};
  end
  assign rst_b = rst_sr[1];

  always_ff @(posedge bclk or negedge rst_b) begin
    if (!rst_b) fs_sr <= '0;
    else        fs_sr <= {fs_sr[1:0], fsync_i};
  end
  assign fs_rise = fs_sr[1] & ~fs_sr[2];

  always_ff @(posedge bclk or negedge rst_b) begin
    if (!rst_b) begin
      edge_cnt     <= '0;
      armed        <= 1'b0;
      ratio_hold_o <= '0;
      tog_o        <= 1'b0;
    end else if (fs_rise) begin
      edge_cnt <= RAT_W'(1);
      armed    <= 1'b1;
      if (armed) begin
        ratio_hold_o <= edge_cnt;
        tog_o        <= ~tog_o;
      end
    end else if (edge_cnt != CNT_MAX) begin
      edge_cnt <= edge_cnt + RAT_W'(1);
    end
  end

endmodule

// File: rtl/afd_frame_timer.sv
// Reference domain: frame period count, stall detection, and capture of
// the ratio handed over from the bit clock domain.
module afd_frame_timer #(
  parameter int RAT_W = 10,
  parameter int PER_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync_i,
  input  logic             tog_i,
  input  logic [RAT_W-1:0] ratio_hold_i,
  output logic [PER_W-1:0] period_o,
  output logic             period_valid_o,
  output logic             stall_o,
  output logic [RAT_W-1:0] ratio_o,
  output logic             ratio_evt_o
);
  localparam logic [PER_W-1:0] PER_MAX = '1;

  logic [2:0]       fs_sr;
  logic [2:0]       tg_sr;
  logic             fs_rise;
  logic             tg_evt;
  logic             seen_edge;
  logic             per_sat;
  logic [PER_W-1:0] per_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_sr <= '0;
      tg_sr <= '0;
    end else begin
      fs_sr <= {fs_sr[1:0], fsync_i};
      tg_sr <= {tg_sr[1:0], tog_i};
    end
  end
  assign fs_rise = fs_sr[1] & ~fs_sr[2];
  assign tg_evt  = tg_sr[1] ^ tg_sr[2];
  assign per_sat = (per_cnt == PER_MAX);
  assign stall_o = (per_cnt == PER_MAX - PER_W'(1)) && !fs_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt        <= '0;
      period_o       <= '0;
      period_valid_o <= 1'b0;
      seen_edge      <= 1'b0;
    end else if (fs_rise) begin
      per_cnt        <= PER_W'(1);
      period_o       <= per_cnt;
      period_valid_o <= seen_edge && !per_sat;
      seen_edge      <= 1'b1;
    end else begin
      if (!per_sat) per_cnt <= per_cnt + PER_W'(1);
      if (stall_o)  period_valid_o <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_o     <= '0;
      ratio_evt_o <= 1'b0;
    end else begin
      ratio_evt_o <= tg_evt;
      if (tg_evt) ratio_o <= ratio_hold_i;
    end
  end

  // R9
  stall_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> !period_valid_o);

endmodule

// File: rtl/afd_classifier.sv
// Matches each frame against the legal sets, checks the bit clock window
// and runs the lock qualification.
module afd_classifier
  import afd_pkg::*;
#(
  parameter int REF_HZ      = 50_000_000,
  parameter int LOCK_FRAMES = 4,
  parameter int RAT_W       = 10,
  parameter int PER_W       = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             low_supply,
  input  logic [RAT_W-1:0] ratio_i,
  input  logic             ratio_evt_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             period_valid_i,
  input  logic             stall_i,
  output frame_cfg_t       cfg_o,
  output logic             locked_o,
  output logic             cfg_err_o
);
  localparam int QW = $clog2(LOCK_FRAMES + 1);
  localparam logic [QW-1:0] QMAX = QW'(LOCK_FRAMES);

  logic          eval_evt;
  logic          stall_evt;
  logic          ratio_hit;
  logic          rate_hit;
  logic          frame_legal;
  frame_cfg_t    new_cfg;
  logic [QW-1:0] qual_cnt;
  logic [QW-1:0] qual_next;

  assign eval_evt  = ratio_evt_i && period_valid_i;
  assign stall_evt = stall_i;

  always_comb begin
    ratio_hit     = 1'b0;
    new_cfg.ratio = '0;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      if (int'(ratio_i) == ratio_value(i)) begin
        ratio_hit     = 1'b1;
        new_cfg.ratio = 4'(i);
      end
    end
  end

  always_comb begin
    rate_hit      = 1'b0;
    new_cfg.rate  = '0;
    new_cfg.fam44 = 1'b0;
    for (int f = 0; f < 2; f++) begin
      for (int i = 0; i < NUM_RATES; i++) begin
        if (period_matches(int'(period_i), nominal_period(REF_HZ, f[0], i))) begin
          rate_hit      = 1'b1;
          new_cfg.rate  = 3'(i);
          new_cfg.fam44 = f[0];
        end
      end
    end
  end

  assign frame_legal = ratio_hit && rate_hit &&
    bclk_in_window(ratio_value(int'(new_cfg.ratio)),
                   rate_value(new_cfg.fam44, int'(new_cfg.rate)), low_supply);

  always_comb begin
    if (qual_cnt != '0 && new_cfg == cfg_o)
      qual_next = (qual_cnt == QMAX) ? QMAX : qual_cnt + QW'(1);
    else
      qual_next = QW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o     <= '0;
      locked_o  <= 1'b0;
      cfg_err_o <= 1'b0;
      qual_cnt  <= '0;
    end else if (stall_evt) begin
      cfg_err_o <= 1'b1;
      locked_o  <= 1'b0;
      qual_cnt  <= '0;
    end else if (eval_evt) begin
      if (!frame_legal) begin
        cfg_err_o <= 1'b1;
        locked_o  <= 1'b0;
        qual_cnt  <= '0;
      end else begin
        cfg_err_o <= 1'b0;
        cfg_o     <= new_cfg;
        qual_cnt  <= qual_next;
        locked_o  <= (qual_next == QMAX);
      end
    end
  end

  // R8
  lock_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(locked_o && cfg_err_o));

  // R6
  lock_rise_on_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(eval_evt));

  // R8
  codes_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(eval_evt && frame_legal) |=> $stable(cfg_o));

  // R7
  mismatch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_evt && !stall_evt && frame_legal && new_cfg != cfg_o) |=> (!locked_o && !cfg_err_o));

  // R9
  stall_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_evt |=> (cfg_err_o && !locked_o));

  // R1
  ratio_code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o.ratio <= 4'(NUM_RATIOS - 1));

endmodule

// File: rtl/afd_top.sv
module afd_top
  import afd_pkg::*;
#(
  parameter int REF_HZ      = 50_000_000,
  parameter int LOCK_FRAMES = 4
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       bclk,
  input  logic       fsync,
  input  logic       low_supply,
  output logic [3:0] ratio_code,
  output logic [2:0] rate_code,
  output logic       fam_44k,
  output logic       locked,
  output logic       cfg_err
);
  localparam int RAT_W = $clog2(2 * ratio_value(NUM_RATIOS - 1));
  localparam int PER_W = $clog2((REF_HZ / FAM44_BASE_HZ) * 21 / 20 + 2);

  logic [RAT_W-1:0] ratio_hold;
  logic             tog;
  logic [PER_W-1:0] period;
  logic             period_valid;
  logic             stall;
  logic [RAT_W-1:0] ratio_ref;
  logic             ratio_evt;
  frame_cfg_t       cfg;

  afd_bclk_counter #(.RAT_W(RAT_W)) u_bclk_cnt (
    .bclk         (bclk),
    .rst_n        (rst_n),
    .fsync_i      (fsync),
    .ratio_hold_o (ratio_hold),
    .tog_o        (tog)
  );

  afd_frame_timer #(.RAT_W(RAT_W), .PER_W(PER_W)) u_timer (
    .clk            (ref_clk),
    .rst_n          (rst_n),
    .fsync_i        (fsync),
    .tog_i          (tog),
    .ratio_hold_i   (ratio_hold),
    .period_o       (period),
    .period_valid_o (period_valid),
    .stall_o        (stall),
    .ratio_o        (ratio_ref),
    .ratio_evt_o    (ratio_evt)
  );

  afd_classifier #(
    .REF_HZ(REF_HZ), .LOCK_FRAMES(LOCK_FRAMES), .RAT_W(RAT_W), .PER_W(PER_W)
  ) u_class (
    .clk            (ref_clk),
    .rst_n          (rst_n),
    .low_supply     (low_supply),
    .ratio_i        (ratio_ref),
    .ratio_evt_i    (ratio_evt),
    .period_i       (period),
    .period_valid_i (period_valid),
    .stall_i        (stall),
    .cfg_o          (cfg),
    .locked_o       (locked),
    .cfg_err_o      (cfg_err)
  );

  assign ratio_code = cfg.ratio;
  assign rate_code  = cfg.rate;
  assign fam_44k    = cfg.fam44;

endmodule

// File: tb/test_afd_top.sv
`timescale 1ns/1ps
module test_afd_top;

  logic       ref_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic       bclk    = 1'b0;
  logic       fsync   = 1'b0;
  logic       low_s   = 1'b0;
  logic [3:0] ratio_code;
  logic [2:0] rate_code;
  logic       fam_44k;
  logic       locked;
  logic       cfg_err;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  int g_ratio = 64;
  int g_rate  = 48000;
  bit g_on    = 1'b0;
  real prev_frame_ns = 0.0;

  int exp_ratio = 0;
  int exp_rate  = 0;
  int exp_fam   = 0;

  // ratio, generated rate, nominal rate, low supply, legal, requirement
  localparam int NV = 14;
  localparam int VEC [NV][6] = '{
    '{ 64,  48000,  48000, 0, 1, 1},
    '{ 64,  88200,  88200, 0, 1, 2},
    '{ 16, 192000, 192000, 0, 1, 1},
    '{128, 192000, 192000, 0, 1, 4},
    '{192, 192000, 192000, 0, 0, 4},
    '{128,  96000,  96000, 1, 1, 4},
    '{192,  96000,  96000, 1, 0, 4},
    '{384,  48000,  48000, 1, 0, 4},
    '{384,  48000,  48000, 0, 1, 4},
    '{ 16,  16000,  16000, 0, 1, 3},
    '{ 16,  14700,  14700, 0, 0, 3},
    '{ 96, 176400, 176400, 0, 1, 2},
    '{ 64,  48720,  48000, 0, 1, 2},
    '{ 64,  49920,  48000, 0, 0, 5}
  };

  afd_top i_afd_top (
    .ref_clk(ref_clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
    .low_supply(low_s), .ratio_code(ratio_code), .rate_code(rate_code),
    .fam_44k(fam_44k), .locked(locked), .cfg_err(cfg_err)
  );

  always #10 ref_clk = ~ref_clk;

  // audio stream generator; settings are taken at each frame start
  initial begin
    forever begin
      if (!g_on) begin
        #1000;
      end else begin
        int  r;
        real hp;
        r  = g_ratio;
        hp = 1.0e9 / (2.0 * r * g_rate);
        for (int i = 0; i < r; i++) begin
          bclk  = 1'b0;
          fsync = (i < r / 2);
          #(hp);
          bclk  = 1'b1;
          #(hp);
        end
      end
    end
  end

  function automatic int tb_ratio_code(int r);
    if ((r & (r - 1)) == 0) return 2 * ($clog2(r) - 4);
    return 2 * ($clog2(r / 3) - 3) + 1;
  endfunction

  function automatic int tb_fam(int nom);
    return (nom % 1000 != 0) ? 1 : 0;
  endfunction

  function automatic int tb_rate_code(int nom);
    int norm;
    norm = tb_fam(nom) ? nom * 160 / 147 : nom;
    case (norm / 8000)
      1: return 0;
      2: return 1;
      3: return 2;
      4: return 3;
      6: return 4;
      12: return 5;
      default: return 6;
    endcase
  endfunction

  function automatic string req_tag(int n);
    case (n)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_codes(string req);
    check(req, "ratio_code", int'(ratio_code), exp_ratio);
    check(req, "rate_code", int'(rate_code), exp_rate);
    check(req, "fam_44k", int'(fam_44k), exp_fam);
  endtask

  task automatic set_stream(int r, int rate, int low);
    low_s   = low[0];
    g_ratio = r;
    g_rate  = rate;
    g_on    = 1'b1;
  endtask

  task automatic run_vec(int r, int rate, int nom, int low, int legal, string req);
    real fr;
    fr = 1.0e9 / rate;
    set_stream(r, rate, low);
    #(prev_frame_ns + 6.5 * fr);
    prev_frame_ns = fr;
    @(negedge ref_clk);
    if (legal != 0) begin
      exp_ratio = tb_ratio_code(r);
      exp_rate  = tb_rate_code(nom);
      exp_fam   = tb_fam(nom);
      check(req, "cfg_err", int'(cfg_err), 0);
      check("R6", "locked", int'(locked), 1);
    end else begin
      check(req, "cfg_err", int'(cfg_err), 1);
      check("R8", "locked", int'(locked), 0);
    end
    check_codes(legal != 0 ? req : "R8");
  endtask

  initial begin
    repeat (195000) @(posedge ref_clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (5) @(negedge ref_clk);
    check("R10", "ratio_code in reset", int'(ratio_code), 0);
    check("R10", "locked in reset", int'(locked), 0);
    check("R10", "cfg_err in reset", int'(cfg_err), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge ref_clk);
    check("R10", "rate_code after reset", int'(rate_code), 0);
    check("R10", "fam_44k after reset", int'(fam_44k), 0);
    check("R10", "locked after reset", int'(locked), 0);

    for (int v = 0; v < NV; v++)
      run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], req_tag(VEC[v][5]));

    // R5: ratio outside the legal set
    run_vec(100, 48000, 48000, 0, 0, "R5");

    // relock at A, then move to B without a gap (R7, R6)
    run_vec(64, 48000, 48000, 0, 1, "R1");
    begin
      real tb_fr;
      int  guard;
      tb_fr = 1.0e9 / 44100;
      set_stream(96, 44100, 0);
      guard = 0;
      @(negedge ref_clk);
      while (locked && guard < 10000) begin
        @(negedge ref_clk);
        guard++;
      end
      exp_ratio = tb_ratio_code(96);
      exp_rate  = tb_rate_code(44100);
      exp_fam   = 1;
      check("R7", "locked falls", int'(locked), 0);
      check("R7", "cfg_err at switch", int'(cfg_err), 0);
      check_codes("R7");
      #(2.5 * tb_fr);
      @(negedge ref_clk);
      check("R6", "locked after 3 frames", int'(locked), 0);
      #(1.0 * tb_fr);
      @(negedge ref_clk);
      check("R6", "locked after 4 frames", int'(locked), 1);
      prev_frame_ns = tb_fr;
    end

    // R9: frame sync stops
    g_on = 1'b0;
    #250000;
    @(negedge ref_clk);
    check("R9", "cfg_err on stall", int'(cfg_err), 1);
    check("R9", "locked on stall", int'(locked), 0);
    check_codes("R8");
    prev_frame_ns = 0.0;
    run_vec(96, 44100, 44100, 0, 1, "R9");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule